// File: doc/BRIEF.md
# Directory-Coherent Cache Controller

This block is the cache-side controller of one node in a directory-based coherence scheme. It manages a small direct-mapped cache. Each line holds one data word and is Invalid, Shared or Exclusive. Processor loads and stores come in on a request channel. A read to a line that is not held becomes a read-miss message to the home directory. A write to a line that is not already Exclusive becomes a write-miss message. The controller then waits for the home's data reply before it answers the processor. When a miss lands on a dirty (Exclusive) line holding another address, the old word is first written back to the home.

The home also sends directed coherence messages on an inbound channel: invalidate, fetch and fetch-with-invalidate. The controller answers them by dropping or downgrading the addressed line. Where data is owed, it returns the word with a write-back message. If the line is not held at all, it returns an acknowledge. Only one processor access can be outstanding, and the processor is stalled until that access completes.

The outbound and inbound message channels use valid/ready. A message stays valid with unchanged fields until it is taken, and the controller takes an inbound message only while `in_ready` is high. The processor request channel is also valid/ready, and `cpu_req_ready` low is the stall. The processor response is a single-cycle `cpu_rsp_valid` pulse with no back-pressure. The address is split into an index (its low log2(LINES) bits) and a tag (the remaining upper bits). Message type codes are given in the requirements.

Top module: `dir_cache_ctrl`

## Requirements
- R1: A read whose line is not held (state Invalid, or another tag and not dirty) sends one outbound message with type 0 (read miss), `out_node` equal to the node id and `out_addr` equal to the request address. It then waits for an inbound type 0 (data reply), answers with the reply data, and leaves the line Shared, so that a later read of the same address hits.
- R2: A write to a line not held Exclusive (including a Shared line with the same tag) sends one type 1 (write miss) message with the request address. On the reply, the line becomes Exclusive holding the write data. The response echoes the write data, and a later read returns it with no message.
- R3: A read to a Shared or Exclusive line with a matching tag, and a write to an Exclusive line with a matching tag, raise `cpu_rsp_valid` in the cycle after acceptance and send no message. A read returns the stored word.
- R4: While a miss is outstanding, `cpu_req_ready` stays low and no response is given until the data reply has been taken.
- R5: A miss whose line is Exclusive with a different tag first sends a type 2 (data write-back) message. That message carries the old address (old tag with the same index) and the old word. The miss message follows it.
- R6: An inbound type 2 (fetch) for a held line sends a type 2 write-back with the line's address and word, and leaves the line Shared. A later read hits, and a later write becomes a write miss.
- R7: An inbound type 3 (fetch with invalidate) for a held line sends a type 2 write-back with the line's word and leaves the line Invalid.
- R8: An inbound type 1 (invalidate) for a held line sets the line Invalid and sends no message.
- R9: An inbound type 1, 2 or 3 for an address whose line is Invalid or holds another tag sends a type 3 (acknowledge) with that address and leaves the line unchanged.
- R10: When the controller is idle and an inbound message is valid, the inbound message is served first. `cpu_req_ready` is low in that cycle and `in_ready` is high.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_type`, `out_addr` and `out_data` stay unchanged.
- R12: An inbound type 0 (data reply) that arrives while no miss is outstanding is taken and discarded. It sends no message, gives no response and fills no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; all lines Invalid |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request taken this cycle; low means stall |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data, or the stored value for a store |
| out_valid | output | 1 | Outbound message present |
| out_ready | input | 1 | Network accepts the outbound message |
| out_type | output | 2 | 0 read miss, 1 write miss, 2 write-back, 3 acknowledge |
| out_node | output | NODE_W | Requesting node id |
| out_addr | output | ADDR_W | Message address |
| out_data | output | DATA_W | Write-back word |
| in_valid | input | 1 | Inbound message present |
| in_ready | output | 1 | Controller takes the inbound message |
| in_type | input | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch with invalidate |
| in_addr | input | ADDR_W | Inbound message address |
| in_data | input | DATA_W | Reply data |

## Verification
A home coherence message and a processor request can arrive in the same idle cycle. The bench provokes this by raising a fetch and a load to the same address on the same falling edge. It then checks that the request is stalled while the fetch is taken, and that the write-back goes out before the load is accepted. The load's own result (hit or miss, and the data returned) is then judged against the line state that the fetch left behind. A bench model of every line's state, tag and word predicts each message and data value during sweeps over all addresses. Other sweeps mix coherence messages to held and aliased addresses. Further sweeps hold the outbound channel back, or send stray replies.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    OUT_RDMISS = 2'd0,
    OUT_WRMISS = 2'd1,
    OUT_WRBACK = 2'd2,
    OUT_ACK    = 2'd3
  } out_msg_e;

  typedef enum logic [1:0] {
    IN_REPLY    = 2'd0,
    IN_INVAL    = 2'd1,
    IN_FETCH    = 2'd2,
    IN_FETCHINV = 2'd3
  } in_msg_e;

  typedef enum logic [2:0] {
    C_IDLE,
    C_SEND_WB,
    C_SEND_MISS,
    C_WAIT,
    C_SEND_COH
  } ctl_st_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_st_e          ra_st,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_st_e          rb_st,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  line_st_e          w_st,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data
);

  line_st_e          st_arr   [LINES];
  logic [TAG_W-1:0]  tag_arr  [LINES];
  logic [DATA_W-1:0] data_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_r;
    logic [TAG_W-1:0]  tag_r;
    logic [DATA_W-1:0] data_r;
    logic              hit_w;

    assign hit_w = we && (w_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r   <= LN_INV;
        tag_r  <= '0;
        data_r <= '0;
      end else if (hit_w) begin
        st_r   <= w_st;
        tag_r  <= w_tag;
        data_r <= w_data;
      end
    end

    assign st_arr[g]   = st_r;
    assign tag_arr[g]  = tag_r;
    assign data_arr[g] = data_r;
  end

  assign ra_st   = st_arr[ra_idx];
  assign ra_tag  = tag_arr[ra_idx];
  assign ra_data = data_arr[ra_idx];
  assign rb_st   = st_arr[rb_idx];
  assign rb_tag  = tag_arr[rb_idx];
  assign rb_data = data_arr[rb_idx];

endmodule

// File: rtl/coh_out_port.sv
module coh_out_port
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  out_msg_e          ld_type,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [1:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              fire
);

  logic              vld_q;
  out_msg_e          type_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign fire = vld_q && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      type_q <= OUT_ACK;
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      vld_q  <= 1'b1;
      type_q <= ld_type;
      addr_q <= ld_addr;
      data_q <= ld_data;
    end else if (fire) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_type  = type_q;
  assign out_addr  = addr_q;
  assign out_data  = data_q;

  // R11: a stalled message keeps its fields
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_type) &&
                                   $stable(out_addr) && $stable(out_data)));

endmodule

// File: rtl/dir_cache_ctrl.sv
module dir_cache_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int LINES   = 4,
  parameter int NODE_W  = 4,
  parameter int NODE_ID = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_type,
  output logic [NODE_W-1:0] out_node,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_st_e           st_q, st_d;
  logic              req_write_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [IDX_W-1:0]  cpu_idx, req_idx, in_idx, ra_idx;
  logic [TAG_W-1:0]  cpu_tag, req_tag, in_tag;

  line_st_e          ra_st, rb_st, lw_st;
  logic [TAG_W-1:0]  ra_tag, rb_tag, lw_tag;
  logic [DATA_W-1:0] ra_data, rb_data, lw_data;
  logic              lw_en;
  logic [IDX_W-1:0]  lw_idx;

  logic              ld;
  out_msg_e          ld_type;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic              out_fire;

  logic              take_req, rsp_set;
  logic [DATA_W-1:0] rsp_val;
  logic              b_held, a_match;
  in_msg_e           in_kind;

  assign cpu_idx = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign req_idx = req_addr_q[IDX_W-1:0];
  assign req_tag = req_addr_q[ADDR_W-1:IDX_W];
  assign in_idx  = in_addr[IDX_W-1:0];
  assign in_tag  = in_addr[ADDR_W-1:IDX_W];
  assign ra_idx  = (st_q == C_IDLE) ? cpu_idx : req_idx;
  assign in_kind = in_msg_e'(in_type);

  coh_line_store #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_st(ra_st), .ra_tag(ra_tag), .ra_data(ra_data),
    .rb_idx(in_idx), .rb_st(rb_st), .rb_tag(rb_tag), .rb_data(rb_data),
    .we(lw_en), .w_idx(lw_idx), .w_st(lw_st), .w_tag(lw_tag), .w_data(lw_data)
  );

  coh_out_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(ld), .ld_type(ld_type), .ld_addr(ld_addr), .ld_data(ld_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_type(out_type),
    .out_addr(out_addr), .out_data(out_data), .fire(out_fire)
  );

  assign out_node      = NODE_W'(NODE_ID);
  assign cpu_req_ready = (st_q == C_IDLE) && !in_valid;
  assign b_held        = (rb_st != LN_INV) && (rb_tag == in_tag);
  assign a_match       = (ra_st != LN_INV) && (ra_tag == cpu_tag);

  always_comb begin
    st_d     = st_q;
    ld       = 1'b0;
    ld_type  = OUT_ACK;
    ld_addr  = in_addr;
    ld_data  = '0;
    lw_en    = 1'b0;
    lw_idx   = in_idx;
    lw_st    = LN_INV;
    lw_tag   = rb_tag;
    lw_data  = rb_data;
    take_req = 1'b0;
    rsp_set  = 1'b0;
    rsp_val  = '0;
    in_ready = 1'b0;
    unique case (st_q)
      C_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (in_kind != IN_REPLY) begin
            if (!b_held) begin
              ld      = 1'b1;
              ld_type = OUT_ACK;
              st_d    = C_SEND_COH;
            end else begin
              lw_en = 1'b1;
              lw_st = (in_kind == IN_FETCH) ? LN_SHR : LN_INV;
              if (in_kind != IN_INVAL) begin
                ld      = 1'b1;
                ld_type = OUT_WRBACK;
                ld_data = rb_data;
                st_d    = C_SEND_COH;
              end
            end
          end
        end else if (cpu_req_valid) begin
          take_req = 1'b1;
          if (!cpu_req_write && a_match) begin
            rsp_set = 1'b1;
            rsp_val = ra_data;
          end else if (cpu_req_write && a_match && ra_st == LN_EXC) begin
            rsp_set = 1'b1;
            rsp_val = cpu_req_wdata;
            lw_en   = 1'b1;
            lw_idx  = cpu_idx;
            lw_st   = LN_EXC;
            lw_tag  = cpu_tag;
            lw_data = cpu_req_wdata;
          end else if (ra_st == LN_EXC && ra_tag != cpu_tag) begin
            ld      = 1'b1;
            ld_type = OUT_WRBACK;
            ld_addr = {ra_tag, cpu_idx};
            ld_data = ra_data;
            lw_en   = 1'b1;
            lw_idx  = cpu_idx;
            lw_st   = LN_INV;
            lw_tag  = ra_tag;
            lw_data = ra_data;
            st_d    = C_SEND_WB;
          end else begin
            ld      = 1'b1;
            ld_type = cpu_req_write ? OUT_WRMISS : OUT_RDMISS;
            ld_addr = cpu_req_addr;
            st_d    = C_SEND_MISS;
          end
        end
      end
      C_SEND_WB: begin
        if (out_fire) begin
          ld      = 1'b1;
          ld_type = req_write_q ? OUT_WRMISS : OUT_RDMISS;
          ld_addr = req_addr_q;
          st_d    = C_SEND_MISS;
        end
      end
      C_SEND_MISS: begin
        if (out_fire) st_d = C_WAIT;
      end
      C_WAIT: begin
        in_ready = (in_kind == IN_REPLY);
        if (in_valid && in_kind == IN_REPLY) begin
          lw_en   = 1'b1;
          lw_idx  = req_idx;
          lw_tag  = req_tag;
          lw_st   = req_write_q ? LN_EXC : LN_SHR;
          lw_data = req_write_q ? req_wdata_q : in_data;
          rsp_set = 1'b1;
          rsp_val = lw_data;
          st_d    = C_IDLE;
        end
      end
      C_SEND_COH: begin
        if (out_fire) st_d = C_IDLE;
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= C_IDLE;
      req_write_q <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= rsp_set;
      if (rsp_set) rsp_data_q <= rsp_val;
      if (take_req) begin
        req_write_q <= cpu_req_write;
        req_addr_q  <= cpu_req_addr;
        req_wdata_q <= cpu_req_wdata;
      end
    end
  end

  assign cpu_rsp_valid = rsp_valid_q;
  assign cpu_rsp_rdata = rsp_data_q;

  // R4: no completion while a miss is in flight
  p_no_rsp_in_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_SEND_WB || st_q == C_SEND_MISS || st_q == C_WAIT) |-> !cpu_rsp_valid);

  // R1: a taken reply completes the access on the next cycle
  p_reply_completes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_WAIT && in_valid && in_ready) |=> cpu_rsp_valid);

  // R3: an accepted request either completes next cycle or starts a message
  p_hit_or_msg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready) |=> (cpu_rsp_valid || out_valid));

  // R5: the miss follows the victim write-back
  p_wb_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_SEND_WB && out_valid && out_ready) |=>
      (out_valid && (out_type == OUT_RDMISS || out_type == OUT_WRMISS)));

  // R10: a cycle that serves an inbound message completes no request
  p_coh_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == C_IDLE && in_valid && cpu_req_valid) |=> !cpu_rsp_valid);

endmodule

// File: tb/tb_dir_cache_ctrl.sv
module tb_dir_cache_ctrl;
  localparam int AW = 6, DW = 16, LN = 4, NW = 4, NID = 5;
  localparam int NA = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cpu_req_valid = 0, cpu_req_ready, cpu_req_write = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic          out_valid, out_ready = 1'b1;
  logic [1:0]    out_type;
  logic [NW-1:0] out_node;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic          in_valid = 0, in_ready;
  logic [1:0]    in_type = '0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;

  dir_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(LN), .NODE_W(NW), .NODE_ID(NID)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_type(out_type), .out_node(out_node), .out_addr(out_addr), .out_data(out_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
    .in_addr(in_addr), .in_data(in_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mem [NA];
  int m_st [LN], m_tg [LN], m_dt [LN];
  int lg_n;
  int lg_t [8], lg_a [8], lg_d [8], lg_nd [8];
  int hold_left = 0;
  bit hold_seen = 0;
  int hold_t, hold_a, hold_d;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic log_out();
    if (lg_n < 8) begin
      lg_t[lg_n] = int'(out_type); lg_a[lg_n] = int'(out_addr);
      lg_d[lg_n] = int'(out_data); lg_nd[lg_n] = int'(out_node);
    end
    lg_n++;
    if (out_type == 2'd2) mem[out_addr] = int'(out_data);
  endtask

  task automatic cpu_op(input bit wr, input int a, input int wd);
    int ix, tg, en, exp_rd, lat;
    int et [2], ea [2], ed [2];
    bit hit, pend, in_go, stall_bad;
    string rq;
    ix = a % LN; tg = a / LN;
    hit = wr ? (m_st[ix] == 2 && m_tg[ix] == tg) : (m_st[ix] != 0 && m_tg[ix] == tg);
    en = 0;
    if (!hit) begin
      if (m_st[ix] == 2 && m_tg[ix] != tg) begin
        et[0] = 2; ea[0] = m_tg[ix] * LN + ix; ed[0] = m_dt[ix]; en = 1;
      end
      et[en] = wr ? 1 : 0; ea[en] = a; ed[en] = 0; en++;
    end
    exp_rd = wr ? wd : (hit ? m_dt[ix] : mem[a]);
    if (wr) begin m_st[ix] = 2; m_tg[ix] = tg; m_dt[ix] = wd; end
    else if (!hit) begin m_st[ix] = 1; m_tg[ix] = tg; m_dt[ix] = mem[a]; end
    rq = hit ? "R3" : (wr ? "R2" : "R1");
    lg_n = 0; pend = 0; in_go = 0; stall_bad = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = wr;
    cpu_req_addr = AW'(a); cpu_req_wdata = DW'(wd);
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    lat = 0;
    while (lat < 100) begin
      @(negedge clk);
      lat++;
      cpu_req_valid = 0;
      if (in_go) begin in_valid = 0; in_go = 0; end
      if (cpu_rsp_valid) break;
      if (out_valid && !out_ready) begin
        if (!hold_seen) begin
          hold_seen = 1; hold_t = int'(out_type); hold_a = int'(out_addr); hold_d = int'(out_data);
        end else begin
          chk(int'(out_type) == hold_t && int'(out_addr) == hold_a && int'(out_data) == hold_d,
              "R11", "held message changed", out_addr, hold_a);
        end
        hold_left--;
        if (hold_left <= 0) begin out_ready = 1; hold_seen = 0; end
      end
      if (out_valid && out_ready) begin
        log_out();
        if (out_type == 2'd0 || out_type == 2'd1) pend = 1;
      end
      if (pend && !in_valid) begin
        in_valid = 1; in_type = 2'd0; in_addr = AW'(a); in_data = DW'(mem[a]);
      end
      #1;
      if (cpu_req_ready) stall_bad = 1;
      if (in_valid && in_ready) begin in_go = 1; pend = 0; end
    end
    chk(lat < 100, rq, "response timeout", lat, 1);
    chk(int'(cpu_rsp_rdata) == exp_rd, rq, "response data", cpu_rsp_rdata, exp_rd);
    chk(lg_n == en, (en == 2) ? "R5" : rq, "message count", lg_n, en);
    for (int i = 0; i < en && i < lg_n; i++) begin
      chk(lg_t[i] == et[i], (et[i] == 2) ? "R5" : rq, "message type", lg_t[i], et[i]);
      chk(lg_a[i] == ea[i], (et[i] == 2) ? "R5" : rq, "message addr", lg_a[i], ea[i]);
      chk(lg_nd[i] == NID, "R1", "node id", lg_nd[i], NID);
      if (et[i] == 2) chk(lg_d[i] == ed[i], "R5", "write-back data", lg_d[i], ed[i]);
    end
    if (hit) chk(lat == 1, "R3", "hit latency", lat, 1);
    else     chk(!stall_bad, "R4", "ready during miss", stall_bad, 0);
  endtask

  task automatic coh_expect(input int t, input int a, output int en, output int et, output int ed,
                            output string rq);
    int ix, tg;
    bit held;
    ix = a % LN; tg = a / LN;
    held = (m_st[ix] != 0 && m_tg[ix] == tg);
    ed = m_dt[ix];
    if (!held) begin en = 1; et = 3; rq = "R9"; end
    else if (t == 1) begin en = 0; et = 0; rq = "R8"; m_st[ix] = 0; end
    else if (t == 2) begin en = 1; et = 2; rq = "R6"; m_st[ix] = 1; end
    else begin en = 1; et = 2; rq = "R7"; m_st[ix] = 0; end
  endtask

  task automatic coh_op(input int t, input int a);
    int en, et, ed;
    string rq;
    coh_expect(t, a, en, et, ed, rq);
    lg_n = 0;
    @(negedge clk);
    in_valid = 1; in_type = 2'(t); in_addr = AW'(a); in_data = '0;
    #1;
    chk(in_ready, "R10", "in_ready when idle", in_ready, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 0;
      if (out_valid && out_ready) log_out();
    end
    chk(lg_n == en, rq, "coherence message count", lg_n, en);
    if (en == 1 && lg_n >= 1) begin
      chk(lg_t[0] == et, rq, "coherence reply type", lg_t[0], et);
      chk(lg_a[0] == a, rq, "coherence reply addr", lg_a[0], a);
      if (et == 2) chk(lg_d[0] == ed, rq, "returned data", lg_d[0], ed);
    end
  endtask

  task automatic conc_op(input int a);
    int en, et, ed;
    string rq;
    coh_expect(2, a, en, et, ed, rq);
    @(negedge clk);
    in_valid = 1; in_type = 2'd2; in_addr = AW'(a);
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = AW'(a);
    #1;
    chk(!cpu_req_ready, "R10", "request ready beside message", cpu_req_ready, 0);
    chk(in_ready, "R10", "message taken first", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(out_valid && int'(out_type) == et, "R10", "coherence reply first", out_type, et);
    chk(!cpu_req_ready, "R10", "request still stalled", cpu_req_ready, 0);
    if (et == 2) chk(int'(out_data) == ed, "R6", "fetch data", out_data, ed);
    if (out_valid && out_type == 2'd2) mem[out_addr] = int'(out_data);
    cpu_op(0, a, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) mem[i] = i * 13 + 100;
    for (int i = 0; i < LN; i++) begin m_st[i] = 0; m_tg[i] = 0; m_dt[i] = 0; end
    repeat (4) @(negedge clk);
    chk(!cpu_rsp_valid, "R4", "reset response", cpu_rsp_valid, 0);
    chk(!out_valid, "R11", "reset out_valid", out_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(cpu_req_ready, "R10", "ready after reset", cpu_req_ready, 1);

    // address sweeps: reads, writes, mixed
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < NA; k++) begin
        int a;
        bit wr;
        a = (k * 37 + p * 5) % NA;
        wr = (p == 1) || (p == 2 && ((k * 5 + p) % 3 == 0));
        cpu_op(wr, a, 1000 + p * 100 + k);
      end

    // coherence messages against held and aliased lines
    for (int k = 0; k < 30; k++) begin
      int a, tgt;
      a = (k * 11 + 3) % NA;
      tgt = (k % 5 == 4) ? (a ^ LN) : a;
      cpu_op(k % 2, a, 3000 + k);
      coh_op(1 + k % 3, tgt);
      cpu_op(0, a, 0);
      cpu_op(1, a, 4000 + k);
    end

    // simultaneous processor request and fetch
    for (int k = 0; k < 4; k++) begin
      cpu_op(k % 2, k * 5, 5000 + k);
      conc_op((k == 3) ? (k * 5) ^ LN : k * 5);
    end

    // outbound back-pressure on a miss
    coh_op(3, 63);
    out_ready = 0; hold_left = 3;
    cpu_op(0, 63, 0);
    out_ready = 1;

    // stray data reply with nothing outstanding
    coh_op(3, 22);
    @(negedge clk);
    in_valid = 1; in_type = 2'd0; in_addr = AW'(22); in_data = 16'h7777;
    #1;
    chk(in_ready, "R12", "stray reply taken", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(!out_valid, "R12", "no message for stray reply", out_valid, 0);
    chk(!cpu_rsp_valid, "R12", "no response for stray reply", cpu_rsp_valid, 0);
    cpu_op(0, 22, 0);
    chk(lg_n == 1, "R12", "line not filled by stray reply", lg_n, 1);

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule